// File: doc/BRIEF.md
# JTAG Scan Shift Engine

This block runs one instruction-register scan, one data-register scan, or a burst of idle clocking on a test access port whose controller state is already known. A request carries the scan kind, a bit count, a starting state and a final state. The engine first asks an external state navigator to move the port into the matching Shift state. It then clocks the bits out one per TCK period. TDI bits are read from a byte-wide source buffer and the TDO bits are packed into a byte-wide result buffer, least significant bit first. Finally it asks the navigator for the requested final state.

The engine does not use a lookup table to reach the Exit1 state. When TMS is raised on the final bit, the engine computes Exit1 itself and uses it as the starting point of the closing navigation. When the final state is a Shift state, or the "keep" code, TMS stays low on the last bit. A later scan of the same kind then continues with no state change at all. The engine drives TCK, TMS and TDI only while `pin_own` is high. At other times a pin multiplexer outside the block gives the pins to the navigator.

State codes on every 5-bit state port are: 0 test-logic-reset, 1 run-test/idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR, and 16 "keep / use the tracked state". Scan kinds are 0 IR scan, 1 DR scan, 2 idle clocking, and 3, which is illegal.

Top module: `jtag_scan_engine`

## Requirements
- R1: An IR scan (kind 0) requests navigation to state 11 and a DR scan (kind 1) requests state 4. The navigation starts from `from_state`, or from the tracked state when `from_state` is 16. No request is made when that starting state already equals the target. `nav_req`, `nav_from` and `nav_to` hold steady until `nav_done`.
- R2: For bit i, TDI is byte i/8, bit i%8 of the source buffer. It is valid from the low half of that TCK period through the rising edge.
- R3: The TDO sampled during the high half of bit i's TCK period is written to bit i%8 of result byte i/8. Each result byte is written once. Bits of the last byte above the scan length are written as 0.
- R4: TMS is 0 on every bit except the last. On the last bit TMS is 1 unless the final state is 4, 11 or 16.
- R5: After a last bit with TMS 1, the tracked state is 5 if the scan was in state 4 and 12 otherwise. A navigation from that state to the final state follows, unless the final state is 16 or already equals it.
- R6: A scan that ends in its own Shift state, followed by a scan of the same kind with `from_state` 16, shifts with no navigation request before or after.
- R7: A length of 0 finishes with `done` and `err` low, with no TCK pulse and no navigation.
- R8: A length of 65535, kind 3, or a state code above 16 finishes at once with `done` and `err` high. No TCK pulse, navigation or state change follows.
- R9: Idle clocking (kind 2) gives exactly N TCK pulses with TMS 0 and TDI 1. It makes no navigation request and no result write, and leaves the tracked state unchanged.
- R10: `done` is a one-cycle pulse that comes only after the final navigation has completed. `start` has no effect while a request is in progress.
- R11: `tap_state` resets to 0 and, after each request, equals the state the port was left in.
- R12: Each bit takes one TCK pulse, made of one clock cycle low and one clock cycle high. `pin_own` is high exactly while the engine is clocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| scan_kind | input | 2 | 0 IR scan, 1 DR scan, 2 idle clocking |
| scan_len | input | LEN_W | Bit count (or TCK count for idle clocking) |
| from_state | input | 5 | Starting state code, 16 = tracked state |
| end_state | input | 5 | Final state code, 16 = stay where the shift leaves the port |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejection flag, valid with done |
| tap_state | output | 5 | Tracked controller state |
| nav_req | output | 1 | Navigation request, held until nav_done |
| nav_from | output | 5 | Navigation starting state |
| nav_to | output | 5 | Navigation target state |
| nav_done | input | 1 | Navigator completion pulse |
| tdi_rd_addr | output | ADDR_W | Source buffer byte address |
| tdi_rd_data | input | 8 | Source buffer byte (combinational read) |
| tdo_wr_en | output | 1 | Result buffer write strobe |
| tdo_wr_addr | output | ADDR_W | Result buffer byte address |
| tdo_wr_data | output | 8 | Result buffer byte |
| pin_own | output | 1 | Engine currently drives TCK/TMS/TDI |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |

## Verification
The bench sweeps both scan kinds over every length from 1 to 20 and rotates through final states that are Shift states, the keep code and ordinary states. Lengths of 7, 8 and 9 bits cover byte boundaries. An off-by-one in the final-bit test would raise TMS a bit early or late, or leave a stale high bit in the last result byte. A wrong Exit1 choice would show up as a bad `nav_from` on the closing navigation. Back-to-back scans that stay in a Shift state check that no needless navigation is requested. The bench also covers zero-length and rejected requests, idle clocking, and a `start` strobed in the middle of a scan. A design that took that strobe would emit extra TCK pulses or a second `done`.

// File: rtl/jtag_scan_pkg.sv
package jtag_scan_pkg;

    localparam logic [4:0] ST_RESET    = 5'd0;
    localparam logic [4:0] ST_SHIFT_DR = 5'd4;
    localparam logic [4:0] ST_EXIT1_DR = 5'd5;
    localparam logic [4:0] ST_SHIFT_IR = 5'd11;
    localparam logic [4:0] ST_EXIT1_IR = 5'd12;
    localparam logic [4:0] ST_KEEP     = 5'd16;

    localparam logic [1:0] KIND_IR   = 2'd0;
    localparam logic [1:0] KIND_DR   = 2'd1;
    localparam logic [1:0] KIND_IDLE = 2'd2;
    localparam logic [1:0] KIND_BAD  = 2'd3;

    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_NAV_PRE  = 2'd1,
        SQ_SHIFT    = 2'd2,
        SQ_NAV_POST = 2'd3
    } seq_phase_e;

    // Exit1 state reached from a Shift state with TMS high
    function automatic logic [4:0] exit1_of(input logic [4:0] s);
        return (s == ST_SHIFT_DR) ? ST_EXIT1_DR : ST_EXIT1_IR;
    endfunction

    // Final states that keep TMS low on the last bit
    function automatic logic stays_in_shift(input logic [4:0] e);
        return (e == ST_SHIFT_DR) || (e == ST_SHIFT_IR) || (e == ST_KEEP);
    endfunction

endpackage

// File: rtl/jtag_shift_core.sv
module jtag_shift_core
    import jtag_scan_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = LEN_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LEN_W-1:0]  len,
    input  logic              raise_last,
    input  logic              idle_run,
    input  logic [7:0]        tdi_byte,
    input  logic              tdo_pin,
    output logic [ADDR_W-1:0] tdi_addr,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic              own,
    output logic              smp_valid,
    output logic              smp_bit,
    output logic [LEN_W-1:0]  smp_idx,
    output logic              smp_last,
    output logic              fin
);

    typedef struct packed {
        logic             active;
        logic             high;
        logic [LEN_W-1:0] idx;
        logic             smp_valid;
        logic             smp_bit;
        logic [LEN_W-1:0] smp_idx;
        logic             smp_last;
        logic             fin;
    } core_regs_t;

    core_regs_t q, d;
    logic       on_last;

    assign on_last = (q.idx == len - LEN_W'(1));

    always_comb begin
        d           = q;
        d.smp_valid = 1'b0;
        d.fin       = 1'b0;
        if (!q.active) begin
            if (go) begin
                d.active = 1'b1;
                d.high   = 1'b0;
                d.idx    = '0;
            end
        end else if (!q.high) begin
            d.high = 1'b1;
        end else begin
            d.high = 1'b0;
            if (!idle_run) begin
                d.smp_valid = 1'b1;
                d.smp_bit   = tdo_pin;
                d.smp_idx   = q.idx;
                d.smp_last  = on_last;
            end
            if (on_last) begin
                d.active = 1'b0;
                d.fin    = 1'b1;
            end else begin
                d.idx = q.idx + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tdi_addr  = q.idx[LEN_W-1:3];
    assign tck       = q.active & q.high;
    assign tms       = q.active & on_last & raise_last & ~idle_run;
    assign tdi       = (idle_run | ~q.active) ? 1'b1 : tdi_byte[q.idx[2:0]];
    assign own       = q.active;
    assign smp_valid = q.smp_valid;
    assign smp_bit   = q.smp_bit;
    assign smp_idx   = q.smp_idx;
    assign smp_last  = q.smp_last;
    assign fin       = q.fin;

    // R12
    tck_high_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tck |=> !tck);

    // R4
    tms_final_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tck && tms) |=> !own);

endmodule

// File: rtl/jtag_tdo_packer.sv
module jtag_tdo_packer #(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = LEN_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              smp_bit,
    input  logic [LEN_W-1:0]  smp_idx,
    input  logic              smp_last,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    typedef struct packed {
        logic [7:0]        acc;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [7:0]        wr_data;
    } pack_regs_t;

    pack_regs_t q, d;
    logic [7:0] base;
    logic [7:0] merged;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        base    = (smp_idx[2:0] == 3'd0) ? 8'h00 : q.acc;
        merged  = base | ({7'b0, smp_bit} << smp_idx[2:0]);
        if (smp_valid) begin
            d.acc = merged;
            if ((smp_idx[2:0] == 3'd7) || smp_last) begin
                d.wr_en   = 1'b1;
                d.wr_addr = smp_idx[LEN_W-1:3];
                d.wr_data = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;

    // R3
    write_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(smp_valid));

endmodule

// File: rtl/jtag_scan_seq.sv
module jtag_scan_seq
    import jtag_scan_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       kind,
    input  logic [LEN_W-1:0] len,
    input  logic [4:0]       from_st,
    input  logic [4:0]       end_st,
    input  logic             nav_done,
    input  logic             shift_fin,
    output logic             nav_req,
    output logic [4:0]       nav_from,
    output logic [4:0]       nav_to,
    output logic             go,
    output logic [LEN_W-1:0] go_len,
    output logic             go_raise,
    output logic             go_idle,
    output logic             done,
    output logic             err,
    output logic [4:0]       tracked
);

    localparam logic [LEN_W-1:0] LEN_LIMIT = '1;

    typedef struct packed {
        seq_phase_e       phase;
        logic [4:0]       track;
        logic [4:0]       end_st;
        logic             idle_run;
        logic             raise;
        logic [LEN_W-1:0] len;
        logic             nav_req;
        logic [4:0]       nav_from;
        logic [4:0]       nav_to;
        logic             go;
        logic             done;
        logic             err;
    } seq_regs_t;

    seq_regs_t  q, d;
    logic       bad_req;
    logic [4:0] target;
    logic [4:0] eff_from;
    logic [4:0] after_shift;

    assign bad_req     = (len == LEN_LIMIT) || (kind == KIND_BAD) ||
                         (from_st > ST_KEEP) || (end_st > ST_KEEP);
    assign target      = (kind == KIND_IR) ? ST_SHIFT_IR : ST_SHIFT_DR;
    assign eff_from    = (from_st == ST_KEEP) ? q.track : from_st;
    assign after_shift = q.raise ? exit1_of(q.track) : q.track;

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        unique case (q.phase)
            SQ_IDLE: begin
                if (start) begin
                    d.end_st   = end_st;
                    d.len      = len;
                    d.idle_run = (kind == KIND_IDLE);
                    d.raise    = !stays_in_shift(end_st);
                    d.err      = 1'b0;
                    if (bad_req) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else if (len == '0) begin
                        d.done = 1'b1;
                    end else if (kind == KIND_IDLE) begin
                        d.raise = 1'b0;
                        d.go    = 1'b1;
                        d.phase = SQ_SHIFT;
                    end else if (eff_from == target) begin
                        d.track = target;
                        d.go    = 1'b1;
                        d.phase = SQ_SHIFT;
                    end else begin
                        d.nav_req  = 1'b1;
                        d.nav_from = eff_from;
                        d.nav_to   = target;
                        d.phase    = SQ_NAV_PRE;
                    end
                end
            end
            SQ_NAV_PRE: begin
                if (nav_done) begin
                    d.nav_req = 1'b0;
                    d.track   = q.nav_to;
                    d.go      = 1'b1;
                    d.phase   = SQ_SHIFT;
                end
            end
            SQ_SHIFT: begin
                if (shift_fin) begin
                    if (q.idle_run) begin
                        d.done  = 1'b1;
                        d.phase = SQ_IDLE;
                    end else begin
                        d.track = after_shift;
                        if ((q.end_st == ST_KEEP) || (q.end_st == after_shift)) begin
                            d.done  = 1'b1;
                            d.phase = SQ_IDLE;
                        end else begin
                            d.nav_req  = 1'b1;
                            d.nav_from = after_shift;
                            d.nav_to   = q.end_st;
                            d.phase    = SQ_NAV_POST;
                        end
                    end
                end
            end
            SQ_NAV_POST: begin
                if (nav_done) begin
                    d.nav_req = 1'b0;
                    d.track   = q.end_st;
                    d.done    = 1'b1;
                    d.phase   = SQ_IDLE;
                end
            end
            default: d.phase = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign nav_req  = q.nav_req;
    assign nav_from = q.nav_from;
    assign nav_to   = q.nav_to;
    assign go       = q.go;
    assign go_len   = q.len;
    assign go_raise = q.raise;
    assign go_idle  = q.idle_run;
    assign done     = q.done;
    assign err      = q.err;
    assign tracked  = q.track;

    // R10
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    nav_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nav_req && !nav_done) |=> (nav_req && $stable(nav_to) && $stable(nav_from)));

    // R8
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && q.phase == SQ_IDLE && (len == LEN_LIMIT || kind == KIND_BAD)) |=> (done && err));

    // R5
    exit1_after_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == SQ_SHIFT && shift_fin && q.raise) |=>
        (tracked == ST_EXIT1_DR || tracked == ST_EXIT1_IR));

endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine
    import jtag_scan_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = LEN_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        scan_kind,
    input  logic [LEN_W-1:0]  scan_len,
    input  logic [4:0]        from_state,
    input  logic [4:0]        end_state,
    output logic              done,
    output logic              err,
    output logic [4:0]        tap_state,
    output logic              nav_req,
    output logic [4:0]        nav_from,
    output logic [4:0]        nav_to,
    input  logic              nav_done,
    output logic [ADDR_W-1:0] tdi_rd_addr,
    input  logic [7:0]        tdi_rd_data,
    output logic              tdo_wr_en,
    output logic [ADDR_W-1:0] tdo_wr_addr,
    output logic [7:0]        tdo_wr_data,
    output logic              pin_own,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo
);

    logic             go;
    logic [LEN_W-1:0] go_len;
    logic             go_raise;
    logic             go_idle;
    logic             shift_fin;
    logic             smp_valid;
    logic             smp_bit;
    logic [LEN_W-1:0] smp_idx;
    logic             smp_last;

    jtag_scan_seq #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind     (scan_kind),
        .len      (scan_len),
        .from_st  (from_state),
        .end_st   (end_state),
        .nav_done (nav_done),
        .shift_fin(shift_fin),
        .nav_req  (nav_req),
        .nav_from (nav_from),
        .nav_to   (nav_to),
        .go       (go),
        .go_len   (go_len),
        .go_raise (go_raise),
        .go_idle  (go_idle),
        .done     (done),
        .err      (err),
        .tracked  (tap_state)
    );

    jtag_shift_core #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .len       (go_len),
        .raise_last(go_raise),
        .idle_run  (go_idle),
        .tdi_byte  (tdi_rd_data),
        .tdo_pin   (tdo),
        .tdi_addr  (tdi_rd_addr),
        .tck       (tck),
        .tms       (tms),
        .tdi       (tdi),
        .own       (pin_own),
        .smp_valid (smp_valid),
        .smp_bit   (smp_bit),
        .smp_idx   (smp_idx),
        .smp_last  (smp_last),
        .fin       (shift_fin)
    );

    jtag_tdo_packer #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_bit  (smp_bit),
        .smp_idx  (smp_idx),
        .smp_last (smp_last),
        .wr_en    (tdo_wr_en),
        .wr_addr  (tdo_wr_addr),
        .wr_data  (tdo_wr_data)
    );

endmodule

// File: tb/jtag_scan_engine_bench.sv
module jtag_scan_engine_bench;

    localparam int LEN_W  = 16;
    localparam int ADDR_W = LEN_W - 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        scan_kind = '0;
    logic [LEN_W-1:0]  scan_len = '0;
    logic [4:0]        from_state = '0;
    logic [4:0]        end_state = '0;
    logic              done, err;
    logic [4:0]        tap_state;
    logic              nav_req;
    logic [4:0]        nav_from, nav_to;
    logic              nav_done = 1'b0;
    logic [ADDR_W-1:0] tdi_rd_addr;
    logic [7:0]        tdi_rd_data;
    logic              tdo_wr_en;
    logic [ADDR_W-1:0] tdo_wr_addr;
    logic [7:0]        tdo_wr_data;
    logic              pin_own, tck, tms, tdi;
    logic              tdo = 1'b0;

    logic [7:0] tdi_mem [8];
    logic [7:0] tdo_mem [8];
    logic       tdi_log [64];
    logic       tms_log [64];
    int         nav_f_log [4];
    int         nav_t_log [4];
    int rise_cnt = 0, nav_cnt = 0, wr_cnt = 0, nav_wait = 0;
    int seed = 0, exp_state = 0;
    int nchk = 0, nerr = 0;

    assign tdi_rd_data = tdi_mem[tdi_rd_addr[2:0]];

    jtag_scan_engine #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_jtag_scan_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .scan_kind(scan_kind),
        .scan_len(scan_len), .from_state(from_state), .end_state(end_state),
        .done(done), .err(err), .tap_state(tap_state), .nav_req(nav_req),
        .nav_from(nav_from), .nav_to(nav_to), .nav_done(nav_done),
        .tdi_rd_addr(tdi_rd_addr), .tdi_rd_data(tdi_rd_data),
        .tdo_wr_en(tdo_wr_en), .tdo_wr_addr(tdo_wr_addr), .tdo_wr_data(tdo_wr_data),
        .pin_own(pin_own), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    always #10 clk = ~clk;

    function automatic logic pat(input int k);
        return ((k * 5 + seed * 3) % 7) < 3;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // target model: log pins at TCK rise, move TDO in the high half
    initial begin
        forever begin
            int k;
            @(posedge tck);
            k = rise_cnt;
            if (k < 64) begin
                tdi_log[k] = tdi;
                tms_log[k] = tms;
            end
            rise_cnt++;
            #5;
            tdo = pat(k);
        end
    end

    // navigator model
    initial begin
        forever begin
            @(negedge clk);
            if (nav_done) nav_done = 1'b0;
            else if (nav_req) begin
                nav_wait++;
                if (nav_wait == 3) begin
                    if (nav_cnt < 4) begin
                        nav_f_log[nav_cnt] = int'(nav_from);
                        nav_t_log[nav_cnt] = int'(nav_to);
                    end
                    nav_cnt++;
                    nav_done = 1'b1;
                    nav_wait = 0;
                end
            end
        end
    end

    // result buffer
    initial begin
        forever begin
            @(negedge clk);
            if (tdo_wr_en) begin
                if (tdo_wr_addr < 8) tdo_mem[tdo_wr_addr[2:0]] = tdo_wr_data;
                wr_cnt++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    task automatic run_scan(input int kind, input int len, input int fr,
                            input int en, input bit poke);
        int tgt, eff, s, fin, nn, prev, bad_i;
        int enf [2];
        int ent [2];
        bit bad, rt, raise, seen, got_err, ok;
        bad   = (len >= 65535) || (kind == 3) || (fr > 16) || (en > 16);
        rt    = (kind == 2);
        prev  = exp_state;
        nn    = 0;
        fin   = exp_state;
        raise = 1'b0;
        if (!bad && len != 0 && !rt) begin
            tgt = (kind == 0) ? 11 : 4;
            eff = (fr == 16) ? exp_state : fr;
            if (eff != tgt) begin enf[nn] = eff; ent[nn] = tgt; nn++; end
            raise = !(en == 4 || en == 11 || en == 16);
            s = raise ? ((tgt == 4) ? 5 : 12) : tgt;
            if (en != 16 && en != s) begin
                enf[nn] = s; ent[nn] = en; nn++; fin = en;
            end else fin = s;
        end
        for (int i = 0; i < 8; i++) begin
            tdi_mem[i] = 8'((i * 29 + seed * 11 + 7) & 255);
            tdo_mem[i] = 8'hFF;
        end
        rise_cnt = 0; nav_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        start = 1'b1; scan_kind = 2'(kind); scan_len = LEN_W'(len);
        from_state = 5'(fr); end_state = 5'(en);
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0; got_err = 1'b0;
        for (int w = 0; w < 3000 && !seen; w++) begin
            if (done) begin
                seen = 1'b1; got_err = err;
            end else begin
                if (poke && w == 4) begin
                    start = 1'b1; scan_kind = 2'd2; scan_len = LEN_W'(3);
                end else start = 1'b0;
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(seen, "R10", "done seen", int'(seen), 1);
        @(negedge clk);
        chk(!done, "R10", "done single pulse", int'(done), 0);
        repeat (8) @(negedge clk);
        chk(got_err == bad, "R8", "err flag", int'(got_err), int'(bad));
        if (bad || len == 0) begin
            chk(rise_cnt == 0 && nav_cnt == 0, bad ? "R8" : "R7", "no activity",
                rise_cnt + nav_cnt, 0);
        end else if (rt) begin
            chk(rise_cnt == len, "R9", "idle clock count", rise_cnt, len);
            ok = 1'b1;
            for (int i = 0; i < len && i < 64; i++)
                if (tms_log[i] != 1'b0 || tdi_log[i] != 1'b1) ok = 1'b0;
            chk(ok, "R9", "idle TMS0/TDI1", int'(ok), 1);
            chk(nav_cnt == 0 && wr_cnt == 0, "R9", "no nav/no write", nav_cnt + wr_cnt, 0);
        end else begin
            chk(rise_cnt == len, "R12", "tck pulses", rise_cnt, len);
            ok = 1'b1; bad_i = -1;
            for (int i = 0; i < len; i++)
                if (tdi_log[i] != tdi_mem[i / 8][i % 8] && ok) begin ok = 1'b0; bad_i = i; end
            chk(ok, "R2", "tdi bit order, first bad index", bad_i, -1);
            ok = 1'b1; bad_i = -1;
            for (int i = 0; i < len; i++)
                if (tms_log[i] != ((i == len - 1) && raise) && ok) begin ok = 1'b0; bad_i = i; end
            chk(ok, "R4", "tms pattern, first bad index", bad_i, -1);
            for (int b = 0; b < 8; b++) begin
                int e;
                e = 0;
                if (b < (len + 7) / 8) begin
                    for (int j = 0; j < 8; j++)
                        if (b * 8 + j < len && pat(b * 8 + j)) e |= (1 << j);
                end else e = 255;
                chk(int'(tdo_mem[b]) == e, "R3", $sformatf("tdo byte %0d", b),
                    int'(tdo_mem[b]), e);
            end
            chk(wr_cnt == (len + 7) / 8, "R3", "write count", wr_cnt, (len + 7) / 8);
            chk(nav_cnt == nn, "R1", "navigation count", nav_cnt, nn);
            for (int i = 0; i < nn && i < nav_cnt; i++) begin
                chk(nav_f_log[i] == enf[i], i == 0 && nn == 2 ? "R1" : "R5", "nav from",
                    nav_f_log[i], enf[i]);
                chk(nav_t_log[i] == ent[i], i == 0 && nn == 2 ? "R1" : "R5", "nav to",
                    nav_t_log[i], ent[i]);
            end
        end
        exp_state = fin;
        chk(int'(tap_state) == fin, "R11", "tracked state", int'(tap_state), fin);
        if (bad || rt || len == 0)
            chk(int'(tap_state) == prev, "R9", "state unchanged", int'(tap_state), prev);
        seed++;
    endtask

    initial begin
        int ends [6];
        ends = '{1, 4, 11, 16, 8, 6};
        repeat (5) @(negedge clk);
        // R11 reset state
        chk(tap_state == 5'd0, "R11", "reset tap_state", int'(tap_state), 0);
        chk(!done && !nav_req && !tck && !pin_own && !tdo_wr_en, "R12", "reset outputs",
            int'({done, nav_req, tck, pin_own, tdo_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // sweep: both kinds, lengths 1..20, rotating final and starting states
        for (int kind = 0; kind < 2; kind++) begin
            for (int len = 1; len <= 20; len++) begin
                int fr;
                case (len % 3)
                    0: fr = 16;
                    1: fr = exp_state;
                    default: fr = 0;
                endcase
                run_scan(kind, len, fr, ends[len % 6], 1'b0);
            end
        end
        // R6: stay in ShiftDR across two DR scans
        run_scan(1, 9, 16, 4, 1'b0);
        run_scan(1, 5, 16, 4, 1'b0);
        chk(nav_cnt == 0, "R6", "no navigation on continued shift", nav_cnt, 0);
        run_scan(0, 6, 16, 11, 1'b0);
        run_scan(0, 3, 16, 11, 1'b0);
        chk(nav_cnt == 0, "R6", "no navigation on continued IR shift", nav_cnt, 0);
        // DR scan ending in ShiftIR: TMS low, then nav ShiftDR -> ShiftIR
        run_scan(1, 4, 16, 11, 1'b0);
        // R9 idle clocking
        run_scan(2, 1, 16, 16, 1'b0);
        run_scan(2, 7, 16, 16, 1'b0);
        // R7 zero length
        run_scan(1, 0, 16, 1, 1'b0);
        // R8 rejects
        run_scan(1, 65535, 16, 1, 1'b0);
        run_scan(3, 5, 16, 1, 1'b0);
        run_scan(0, 5, 17, 1, 1'b0);
        run_scan(0, 5, 16, 20, 1'b0);
        // R10 start while busy is ignored
        run_scan(1, 12, 1, 1, 1'b1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule